// File: doc/BRIEF.md
# Four-Bit Cascadable ALU Slice with Register File

This block is one 4-bit slice of a microprogrammed datapath. It holds a sixteen-word register file with two independent read addresses and an accumulator-style Q register. Each cycle a 9-bit microinstruction picks an operand pair, an ALU function and a destination. The destination can write the register addressed by B, the Q register, both, or neither, and can shift the result one place up or down through shift lines at each end.

The ALU result is combinational from the current inputs and register contents. The Y bus, carry-out and the zero, sign and overflow flags are also combinational. Register and Q writes take effect on the rising clock edge.

The microinstruction, addresses, data and shift lines are plain control pins sampled every cycle. No valid/ready handshake is used, because the slice accepts a new microinstruction on every clock. The idle microinstruction is source pair (A,B), function add, destination no-load, carry-in 0, with both addresses at 0.

Top module: `bitslice_alu`

## Requirements
- R1: `src_sel` picks the (R,S) pair: 0=(A,Q), 1=(A,B), 2=(0,Q), 3=(0,B), 4=(0,A), 5=(D,A), 6=(D,Q), 7=(D,0). Here A and B are the words read at `addr_a` and `addr_b`.
- R2: `fn_sel` picks F: 0=R+S+cin, 1=S+~R+cin, 2=R+~S+cin, 3=R|S, 4=R&S, 5=~R&S, 6=R^S, 7=~(R^S). For codes 3 to 7, `cout` and `ovf` are 0.
- R3: Subtraction adds the inverted subtrahend and carry-in. Equal operands with cin=1 therefore give F=0 and cout=1.
- R4: `dst_sel`=0 loads Q with F at the clock edge, writes no register, and puts F on Y.
- R5: `dst_sel`=1 writes neither the register file nor Q, and puts F on Y.
- R6: `dst_sel`=2 writes F into register B and puts the A read word, taken before the write, on Y.
- R7: `dst_sel`=3 writes F into register B and puts F on Y. Q is unchanged.
- R8: `dst_sel`=4 and 5 write {ram_hi_in, F[3:1]} into register B and drive `ram_lo_out`=F[0]. Code 4 also loads Q with {q_hi_in, Q[3:1]} and drives `q_lo_out`=Q[0]. Y is F in both cases.
- R9: `dst_sel`=6 and 7 write {F[2:0], ram_lo_in} into register B and drive `ram_hi_out`=F[3]. Code 6 also loads Q with {Q[2:0], q_lo_in} and drives `q_hi_out`=Q[3]. Y is F in both cases.
- R10: A shift-line output that the current destination does not use is driven 0.
- R11: `zero` is 1 when F is 0. `sign` is F[3]. `ovf` is the XOR of the carries into and out of bit 3. `cout` is the carry out of bit 3.
- R12: With `y_oe` low, `y_out` is 0. The flags are unaffected.
- R13: Reset clears all sixteen registers and Q to 0.
- R14: The two read addresses are independent, and both may name the same register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low reset of register file and Q |
| src_sel | input | 3 | Operand pair select |
| fn_sel | input | 3 | ALU function select |
| dst_sel | input | 3 | Destination and shift control |
| addr_a | input | 4 | Read address A |
| addr_b | input | 4 | Read and write address B |
| d_in | input | 4 | Direct data operand |
| cin | input | 1 | Carry-in |
| y_oe | input | 1 | Y bus enable |
| ram_lo_in | input | 1 | Fill bit for bit 0 on register up shift |
| ram_hi_in | input | 1 | Fill bit for bit 3 on register down shift |
| q_lo_in | input | 1 | Fill bit for Q bit 0 on up shift |
| q_hi_in | input | 1 | Fill bit for Q bit 3 on down shift |
| ram_lo_out | output | 1 | F bit 0 during register down shift |
| ram_hi_out | output | 1 | F bit 3 during register up shift |
| q_lo_out | output | 1 | Q bit 0 during Q down shift |
| q_hi_out | output | 1 | Q bit 3 during Q up shift |
| y_out | output | 4 | Y bus |
| cout | output | 1 | Carry-out |
| zero | output | 1 | F equals zero |
| sign | output | 1 | F most significant bit |
| ovf | output | 1 | Signed overflow |

## Verification
Register B can be written in the same cycle that A or Q is read, including when A and B name the same register. Destination 2 makes that collision visible, because Y must show the old word while the new word lands. Q can also shift in the same cycle that the register file shifts, with separate fill bits at each end. The bench provokes these cases with directed A==B writes and shifts with mixed fill bits, and through random microinstructions over a small address range. It judges each by reading the register or Q back through a later pass-through microinstruction and comparing with its own model.

// File: rtl/bsalu_pkg.sv
package bsalu_pkg;
  typedef enum logic [2:0] {
    PAIR_A_Q, PAIR_A_B, PAIR_Z_Q, PAIR_Z_B,
    PAIR_Z_A, PAIR_D_A, PAIR_D_Q, PAIR_D_Z
  } pair_e;

  typedef enum logic [2:0] {
    OP_SUM, OP_S_MINUS_R, OP_R_MINUS_S, OP_IOR,
    OP_AND, OP_ANDN, OP_XOR, OP_XNOR
  } op_e;

  typedef enum logic [2:0] {
    DST_Q_ONLY, DST_NONE, DST_B_YA, DST_B,
    DST_BQ_DN, DST_B_DN, DST_BQ_UP, DST_B_UP
  } dst_e;
endpackage

// File: rtl/bsalu_regfile.sv
module bsalu_regfile #(
  parameter int W     = 4,
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] ra,
  input  logic [AW-1:0] rb,
  input  logic          wr_en,
  input  logic [W-1:0]  wd,
  output logic [W-1:0]  rd_a,
  output logic [W-1:0]  rd_b
);
  logic [W-1:0] mem [DEPTH];

  assign rd_a = mem[ra];
  assign rd_b = mem[rb];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (wr_en) begin
      mem[rb] <= wd;
    end
  end

  AST_RF_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> mem[$past(rb)] == $past(wd)); // R7
endmodule

// File: rtl/bsalu_alu.sv
module bsalu_alu
  import bsalu_pkg::*;
#(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] a_word,
  input  logic [W-1:0] b_word,
  input  logic [W-1:0] q_word,
  input  logic [W-1:0] d_word,
  input  pair_e        pair,
  input  op_e          op,
  input  logic         cin,
  output logic [W-1:0] f,
  output logic         cout,
  output logic         ovf
);
  logic [W-1:0] r, s, x, y;
  logic [W-2:0] low_sum;
  logic         c_top_in, top_sum;
  logic         arith;

  always_comb begin
    unique case (pair)
      PAIR_A_Q: begin r = a_word; s = q_word; end
      PAIR_A_B: begin r = a_word; s = b_word; end
      PAIR_Z_Q: begin r = '0;     s = q_word; end
      PAIR_Z_B: begin r = '0;     s = b_word; end
      PAIR_Z_A: begin r = '0;     s = a_word; end
      PAIR_D_A: begin r = d_word; s = a_word; end
      PAIR_D_Q: begin r = d_word; s = q_word; end
      default:  begin r = d_word; s = '0;     end
    endcase
  end

  always_comb begin
    arith = 1'b1;
    unique case (op)
      OP_S_MINUS_R: begin x = s; y = ~r; end
      OP_R_MINUS_S: begin x = r; y = ~s; end
      OP_SUM:       begin x = r; y = s;  end
      default:      begin x = r; y = s; arith = 1'b0; end
    endcase
  end

  // carry into the top bit is kept apart so overflow can use it
  assign {c_top_in, low_sum} = {1'b0, x[W-2:0]} + {1'b0, y[W-2:0]} + {{(W-1){1'b0}}, cin};
  logic c_top_out;
  assign {c_top_out, top_sum} = {1'b0, x[W-1]} + {1'b0, y[W-1]} + {1'b0, c_top_in};

  always_comb begin
    unique case (op)
      OP_IOR:  f = r | s;
      OP_AND:  f = r & s;
      OP_ANDN: f = ~r & s;
      OP_XOR:  f = r ^ s;
      OP_XNOR: f = ~(r ^ s);
      default: f = {top_sum, low_sum};
    endcase
  end

  assign cout = arith & c_top_out;
  assign ovf  = arith & (c_top_out ^ c_top_in);

  AST_EQUAL_SUB_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_R_MINUS_S && r == s && cin) |-> (f == '0 && cout)); // R3
  AST_LOGIC_NO_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
    (op inside {OP_IOR, OP_AND, OP_ANDN, OP_XOR, OP_XNOR}) |-> (!cout && !ovf)); // R2
endmodule

// File: rtl/bsalu_dest.sv
module bsalu_dest
  import bsalu_pkg::*;
#(
  parameter int W = 4
) (
  input  dst_e         dst,
  input  logic [W-1:0] f,
  input  logic [W-1:0] a_word,
  input  logic [W-1:0] q_word,
  input  logic         ram_lo_in,
  input  logic         ram_hi_in,
  input  logic         q_lo_in,
  input  logic         q_hi_in,
  output logic         rf_we,
  output logic [W-1:0] rf_wd,
  output logic         q_we,
  output logic [W-1:0] q_wd,
  output logic [W-1:0] y_sel,
  output logic         ram_lo_out,
  output logic         ram_hi_out,
  output logic         q_lo_out,
  output logic         q_hi_out
);
  logic dn, up;
  assign dn = (dst == DST_BQ_DN) || (dst == DST_B_DN);
  assign up = (dst == DST_BQ_UP) || (dst == DST_B_UP);

  always_comb begin
    rf_we = (dst != DST_Q_ONLY) && (dst != DST_NONE);
    if (dn)      rf_wd = {ram_hi_in, f[W-1:1]};
    else if (up) rf_wd = {f[W-2:0], ram_lo_in};
    else         rf_wd = f;

    q_we = (dst == DST_Q_ONLY) || (dst == DST_BQ_DN) || (dst == DST_BQ_UP);
    unique case (dst)
      DST_BQ_DN: q_wd = {q_hi_in, q_word[W-1:1]};
      DST_BQ_UP: q_wd = {q_word[W-2:0], q_lo_in};
      default:   q_wd = f;
    endcase

    y_sel = (dst == DST_B_YA) ? a_word : f;
  end

  assign ram_lo_out = dn & f[0];
  assign ram_hi_out = up & f[W-1];
  assign q_lo_out   = (dst == DST_BQ_DN) & q_word[0];
  assign q_hi_out   = (dst == DST_BQ_UP) & q_word[W-1];
endmodule

// File: rtl/bitslice_alu.sv
module bitslice_alu
  import bsalu_pkg::*;
#(
  parameter int W     = 4,
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [2:0]    src_sel,
  input  logic [2:0]    fn_sel,
  input  logic [2:0]    dst_sel,
  input  logic [AW-1:0] addr_a,
  input  logic [AW-1:0] addr_b,
  input  logic [W-1:0]  d_in,
  input  logic          cin,
  input  logic          y_oe,
  input  logic          ram_lo_in,
  input  logic          ram_hi_in,
  input  logic          q_lo_in,
  input  logic          q_hi_in,
  output logic          ram_lo_out,
  output logic          ram_hi_out,
  output logic          q_lo_out,
  output logic          q_hi_out,
  output logic [W-1:0]  y_out,
  output logic          cout,
  output logic          zero,
  output logic          sign,
  output logic          ovf
);
  logic [W-1:0] a_word, b_word, q_reg, f, rf_wd, q_wd, y_sel;
  logic         rf_we, q_we;
  dst_e         dst;

  assign dst = dst_e'(dst_sel);

  bsalu_regfile #(.W(W), .DEPTH(DEPTH)) rf_i (
    .clk(clk), .rst_n(rst_n), .ra(addr_a), .rb(addr_b),
    .wr_en(rf_we), .wd(rf_wd), .rd_a(a_word), .rd_b(b_word)
  );

  bsalu_alu #(.W(W)) alu_i (
    .clk(clk), .rst_n(rst_n), .a_word(a_word), .b_word(b_word),
    .q_word(q_reg), .d_word(d_in), .pair(pair_e'(src_sel)),
    .op(op_e'(fn_sel)), .cin(cin), .f(f), .cout(cout), .ovf(ovf)
  );

  bsalu_dest #(.W(W)) dest_i (
    .dst(dst), .f(f), .a_word(a_word), .q_word(q_reg),
    .ram_lo_in(ram_lo_in), .ram_hi_in(ram_hi_in),
    .q_lo_in(q_lo_in), .q_hi_in(q_hi_in),
    .rf_we(rf_we), .rf_wd(rf_wd), .q_we(q_we), .q_wd(q_wd),
    .y_sel(y_sel), .ram_lo_out(ram_lo_out), .ram_hi_out(ram_hi_out),
    .q_lo_out(q_lo_out), .q_hi_out(q_hi_out)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q_reg <= '0;
    else if (q_we) q_reg <= q_wd;
  end

  assign y_out = y_oe ? y_sel : '0;
  assign zero  = (f == '0);
  assign sign  = f[W-1];

  AST_Q_LOAD_F: assert property (@(posedge clk) disable iff (!rst_n)
    (dst == DST_Q_ONLY) |=> q_reg == $past(f)); // R4
  AST_Q_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (dst inside {DST_NONE, DST_B_YA, DST_B, DST_B_DN, DST_B_UP}) |=> $stable(q_reg)); // R5
  AST_SHIFT_LINES_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (dst_sel < 3'd4) |-> (!ram_lo_out && !ram_hi_out && !q_lo_out && !q_hi_out)); // R10
  AST_ZERO_MATCHES_Y: assert property (@(posedge clk) disable iff (!rst_n)
    (y_oe && dst != DST_B_YA) |-> (zero == (y_out == '0))); // R11
endmodule

// File: tb/bitslice_alu_tb_top.sv
module bitslice_alu_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0] src_sel = 3'd1, fn_sel = 3'd0, dst_sel = 3'd1;
  logic [3:0] addr_a = 4'd0, addr_b = 4'd0, d_in = 4'd0;
  logic cin = 1'b0, y_oe = 1'b1;
  logic ram_lo_in = 1'b0, ram_hi_in = 1'b0, q_lo_in = 1'b0, q_hi_in = 1'b0;
  logic ram_lo_out, ram_hi_out, q_lo_out, q_hi_out;
  logic [3:0] y_out;
  logic cout, zero, sign, ovf;

  int checks = 0;
  int failures = 0;
  logic [3:0] m_rf [16];
  logic [3:0] m_q;

  always #10 clk = ~clk;

  bitslice_alu dut_i (
    .clk(clk), .rst_n(rst_n), .src_sel(src_sel), .fn_sel(fn_sel), .dst_sel(dst_sel),
    .addr_a(addr_a), .addr_b(addr_b), .d_in(d_in), .cin(cin), .y_oe(y_oe),
    .ram_lo_in(ram_lo_in), .ram_hi_in(ram_hi_in), .q_lo_in(q_lo_in), .q_hi_in(q_hi_in),
    .ram_lo_out(ram_lo_out), .ram_hi_out(ram_hi_out), .q_lo_out(q_lo_out), .q_hi_out(q_hi_out),
    .y_out(y_out), .cout(cout), .zero(zero), .sign(sign), .ovf(ovf)
  );

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // returns {ovf, cout, f}
  function automatic logic [5:0] ref_alu(logic [3:0] r, logic [3:0] s, logic [2:0] fn, logic c);
    logic [3:0] x, y, f;
    logic [4:0] sum;
    case (fn)
      3'd0: begin x = r; y = s; end
      3'd1: begin x = s; y = ~r; end
      3'd2: begin x = r; y = ~s; end
      default: begin x = 0; y = 0; end
    endcase
    if (fn <= 3'd2) begin
      sum = {1'b0, x} + {1'b0, y} + {4'b0, c};
      f = sum[3:0];
      return {(x[3] == y[3]) && (f[3] != x[3]), sum[4], f};
    end
    case (fn)
      3'd3: f = r | s;
      3'd4: f = r & s;
      3'd5: f = ~r & s;
      3'd6: f = r ^ s;
      default: f = ~(r ^ s);
    endcase
    return {2'b00, f};
  endfunction

  task automatic step(logic [2:0] src, logic [2:0] fn, logic [2:0] dst,
                      logic [3:0] a, logic [3:0] b, logic [3:0] d, logic c, logic oe,
                      logic rli, logic rhi, logic qli, logic qhi, string ytag);
    logic [3:0] ra, rb, r, s, f, yexp;
    logic [5:0] res;
    @(negedge clk);
    src_sel = src; fn_sel = fn; dst_sel = dst; addr_a = a; addr_b = b; d_in = d;
    cin = c; y_oe = oe; ram_lo_in = rli; ram_hi_in = rhi; q_lo_in = qli; q_hi_in = qhi;
    #2;
    ra = m_rf[a]; rb = m_rf[b];
    case (src)
      3'd0: begin r = ra; s = m_q; end
      3'd1: begin r = ra; s = rb; end
      3'd2: begin r = 0;  s = m_q; end
      3'd3: begin r = 0;  s = rb; end
      3'd4: begin r = 0;  s = ra; end
      3'd5: begin r = d;  s = ra; end
      3'd6: begin r = d;  s = m_q; end
      default: begin r = d; s = 0; end
    endcase
    res = ref_alu(r, s, fn, c);
    f = res[3:0];
    yexp = !oe ? 4'h0 : (dst == 3'd2 ? ra : f);
    check(oe ? ytag : "R12 y disabled", {4'h0, y_out}, {4'h0, yexp});
    check("R2 cout", {7'h0, cout}, {7'h0, res[4]});
    check("R11 flags", {5'h0, zero, sign, ovf}, {5'h0, f == 0, f[3], res[5]});
    check("R10 shift outs", {4'h0, ram_lo_out, ram_hi_out, q_lo_out, q_hi_out},
          {4'h0, (dst == 4 || dst == 5) & f[0], (dst == 6 || dst == 7) & f[3],
           (dst == 4) & m_q[0], (dst == 6) & m_q[3]});
    @(posedge clk);
    #1;
    case (dst)
      3'd0: m_q = f;
      3'd2, 3'd3: m_rf[b] = f;
      3'd4: begin m_rf[b] = {rhi, f[3:1]}; m_q = {qhi, m_q[3:1]}; end
      3'd5: m_rf[b] = {rhi, f[3:1]};
      3'd6: begin m_rf[b] = {f[2:0], rli}; m_q = {m_q[2:0], qli}; end
      3'd7: m_rf[b] = {f[2:0], rli};
      default: ;
    endcase
  endtask

  task automatic peek_reg(logic [3:0] k, string tag);
    step(3'd4, 3'd0, 3'd1, k, 4'd0, 4'd0, 1'b0, 1'b1, 0, 0, 0, 0, tag);
  endtask

  task automatic peek_q(string tag);
    step(3'd2, 3'd0, 3'd1, 4'd0, 4'd0, 4'd0, 1'b0, 1'b1, 0, 0, 0, 0, tag);
  endtask

  function automatic string dtag(logic [2:0] dst);
    case (dst)
      3'd0: return "R4 q-load";
      3'd1: return "R5 no-load";
      3'd2: return "R6 y-from-a";
      3'd3: return "R7 write-b";
      3'd4, 3'd5: return "R8 down";
      default: return "R9 up";
    endcase
  endfunction

  initial begin
    #(200000 * 20);
    failures++;
    $display("FAIL watchdog: actual hung expected done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int unsigned seed;
    seed = 32'h5EED_2024;
    void'($urandom(seed));
    for (int i = 0; i < 16; i++) m_rf[i] = 4'h0;
    m_q = 4'h0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R13: reset state
    for (int k = 0; k < 16; k++) peek_reg(k[3:0], "R13 reset reg");
    peek_q("R13 reset q");

    // fill registers through D with dest 3 (R7)
    for (int k = 0; k < 16; k++)
      step(3'd7, 3'd0, 3'd3, 4'd0, k[3:0], k[3:0] ^ 4'h5, 1'b0, 1'b1, 0, 0, 0, 0, "R7 load");
    step(3'd7, 3'd0, 3'd0, 4'd0, 4'd0, 4'h9, 1'b0, 1'b1, 0, 0, 0, 0, "R4 load q");
    peek_q("R4 q readback");

    // R1: every source pair
    for (int sp = 0; sp < 8; sp++)
      step(sp[2:0], 3'd0, 3'd1, 4'd3, 4'd9, 4'h2, 1'b0, 1'b1, 0, 0, 0, 0, "R1 source pair");
    // R14: same and different addresses
    step(3'd1, 3'd0, 3'd1, 4'd6, 4'd6, 4'h0, 1'b1, 1'b1, 0, 0, 0, 0, "R14 same addr");
    // R3: equal operands, cin 1, both subtractions
    step(3'd5, 3'd2, 3'd1, 4'd4, 4'd0, 4'h1, 1'b1, 1'b1, 0, 0, 0, 0, "R3 r-s equal");
    step(3'd5, 3'd1, 3'd1, 4'd4, 4'd0, 4'h1, 1'b1, 1'b1, 0, 0, 0, 0, "R3 s-r equal");
    step(3'd7, 3'd0, 3'd1, 4'd0, 4'd0, 4'h7, 1'b1, 1'b1, 0, 0, 0, 0, "R11 overflow 7+0+1");
    // R6: A==B collision, Y shows old word
    step(3'd7, 3'd0, 3'd2, 4'd8, 4'd8, 4'hE, 1'b0, 1'b1, 0, 0, 0, 0, "R6 collide");
    peek_reg(4'd8, "R6 readback");
    // R8 / R9 shifts with fill bits, Q shifting alongside
    step(3'd7, 3'd0, 3'd4, 4'd0, 4'd2, 4'hB, 1'b0, 1'b1, 0, 1, 0, 1, "R8 down bq");
    peek_reg(4'd2, "R8 reg readback");
    peek_q("R8 q readback");
    step(3'd7, 3'd0, 3'd6, 4'd0, 4'd3, 4'hA, 1'b0, 1'b1, 1, 0, 1, 0, "R9 up bq");
    peek_reg(4'd3, "R9 reg readback");
    peek_q("R9 q readback");
    step(3'd7, 3'd0, 3'd5, 4'd0, 4'd4, 4'h6, 1'b0, 1'b1, 0, 0, 1, 1, "R8 down b only");
    peek_q("R8 q untouched");
    // R12: Y disabled
    step(3'd7, 3'd0, 3'd1, 4'd0, 4'd0, 4'hF, 1'b0, 1'b0, 0, 0, 0, 0, "R12");
    // R5: no-load leaves state
    step(3'd7, 3'd0, 3'd1, 4'd0, 4'd5, 4'h3, 1'b0, 1'b1, 0, 0, 0, 0, "R5 no-load");
    peek_reg(4'd5, "R5 reg unchanged");

    for (int n = 0; n < 600; n++) begin
      logic [2:0] dst;
      dst = 3'($urandom);
      step(3'($urandom), 3'($urandom), dst, 4'($urandom % 4), 4'($urandom % 4),
           4'($urandom), 1'($urandom), ($urandom % 10) != 0,
           1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom), dtag(dst));
    end
    for (int k = 0; k < 4; k++) peek_reg(k[3:0], "R14 final regs");
    peek_q("R4 final q");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule